// File: doc/BRIEF.md
# Serial NOR Flash Command and Address Front End

This block sits behind a serial shifter in a NOR flash target. It works one byte at a time. It takes a chip-select, a strobe for each received byte, and a request for the next byte to transmit. The first byte of every chip-select frame is decoded as an opcode. The block then collects the address bytes and any dummy bytes that follow. It holds the address-width flag, the extended-address register, the write-enable latch and three configuration registers, and it returns their values on register-read opcodes.

For array operations it drives a single-cycle request to an external memory port. Each request carries an operation code and the assembled byte address. The memory port treats a program request as flash-style: the stored byte becomes old AND new, so a program can only turn bits from 1 to 0. Read data from the memory port is passed straight to the transmit byte in the same cycle as the request.

A two-frame sequence resets the register file. Both that sequence and the power-on reset set the volatile registers from the nonvolatile configuration word.

Top module: `spiflash_cmd_front`

## Requirements
- R1: After power-on reset the nonvolatile word is 0x8FFF and the registers derive from it. This gives a volatile configuration of 0x83, an enhanced volatile configuration of 0xDF, the extended-address register at 0x00, 3-byte addressing and write-enable cleared. Opcodes 0x85, 0x65, 0xB5 (low byte then high byte), 0xC8 and 0x70 return these values on successive transmit requests.
- R2: Opcode 0xB7 sets 4-byte address mode and opcode 0xE9 clears it; neither takes further bytes. The flag status byte from opcode 0x70 has bit 7 always set and bit 0 equal to the mode flag.
- R3: Legacy array opcodes (reads 0x03, 0x0B, 0x3B, 0x6B, 0xBB, 0xEB; programs 0x02, 0xA2, 0x32; erases 0x20, 0xD8) take their address most significant byte first. The address is 3 bytes long, or 4 bytes when the mode flag is set. With 3 bytes, extended-address bits [1:0] times 16 MiB are added.
- R4: Opcodes 0x13, 0x0C, 0x3C, 0x6C, 0xBC, 0xEC, 0x12, 0x21 and 0xDC always take a 4-byte address, and the extended-address register is not applied.
- R5: Every read opcode other than 0x03 and 0x13 consumes, after the address, a number of dummy bytes equal to volatile configuration bits [7:4]. Plain reads consume none.
- R6: In the array-read phase, each transmit request issues one memory request with op 0 (read) at the current address. The transmit byte equals the memory read data, and the address then increments by one.
- R7: In the program phase, each received byte issues one memory request with op 1 (program), the byte as write data and the current address. The address then increments. Storage applies old AND new.
- R8: An erase opcode issues exactly one memory request, in the cycle after its last address byte. The op is 2 for 0x20/0x21 (4 KiB) and 3 for 0xD8/0xDC (sector).
- R9: Opcode 0x06 sets write-enable and 0x04 clears it. Opcode 0xC8 returns the extended-address register. Opcode 0xC5 loads it from the next byte only when write-enable is set; otherwise the opcode is ignored.
- R10: Opcode 0xB1 writes the nonvolatile word from two bytes, low byte first. Opcodes 0x81 and 0x61 write the volatile and enhanced volatile configuration from one byte. All three are ignored without write-enable.
- R11: Opcode 0x99 resets only if the opcode just before it was 0x66. Reset clears write-enable and then derives the registers from the nonvolatile word:
  - volatile configuration = {nv[15:12], nv[11:9]!=7, 0, 1, 1};
  - enhanced volatile configuration = 0x1F plus bit 6 = nv[2] plus bit 7 = nv[3];
  - 4-byte mode on when nv[0] is 0;
  - extended-address register = 3 when nv[1] is 0, otherwise 0.
- R12: Raising chip-select abandons any partial frame and issues no memory request. The next frame's first byte is decoded as an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset |
| csN | input | 1 | Active-low chip-select, frames a command |
| rxValid | input | 1 | One-cycle strobe: a received byte is on rxData |
| rxData | input | 8 | Received byte |
| txReq | input | 1 | One-cycle request for the next byte to transmit |
| txData | output | 8 | Byte to transmit, valid while txReq is high |
| memReq | output | 1 | One-cycle memory request |
| memOp | output | 2 | 0 read, 1 program (AND-merge), 2 erase 4 KiB, 3 erase sector |
| memAddr | output | ADDR_W | Byte address of the request |
| memWdata | output | 8 | Program data |
| memRdata | input | 8 | Read data returned by the memory port for memAddr |

## Verification
Array operations are tried with legacy opcodes in both address modes and with dedicated 4-byte opcodes, under non-zero extended-address values. This separates a wrongly applied extended offset from a wrong address length. Fast reads run with eight and with two dummy bytes: a miscount either shifts the first request or leaves it missing. Register writes are sent with write-enable both set and cleared. The reset sequence is tried bare, interrupted by another opcode, and complete from a modified nonvolatile word whose every derived field differs from its power-on value.

// File: rtl/spiflash_pkg.sv
package spiflash_pkg;

  typedef enum logic [1:0] {
    MEM_READ       = 2'd0,
    MEM_PROG       = 2'd1,
    MEM_ERASE_4K   = 2'd2,
    MEM_ERASE_SECT = 2'd3
  } memOp_e;

  typedef enum logic [2:0] {
    RS_NONE, RS_ARRAY, RS_FLAG, RS_EAR, RS_NVCFG, RS_VCFG, RS_EVCFG
  } rdSel_e;

  typedef enum logic [3:0] {
    ST_OPC, ST_ADDR, ST_DUMMY, ST_ARRRD, ST_PROG, ST_ERASE, ST_REGRD, ST_REGWR, ST_SKIP
  } st_e;

  typedef struct packed {
    logic   shiftAddr;
    logic   addr4;
    logic   incAddr;
    logic   setFour;
    logic   clrFour;
    logic   setWe;
    logic   clrWe;
    logic   doReset;
    logic   loadEar;
    logic   loadVcfg;
    logic   loadEvcfg;
    logic   nvLow;
    logic   nvHigh;
    rdSel_e rdSel;
    logic   hiByte;
  } dpCtl_t;

  typedef struct packed {
    logic   force4;
    logic   hasDummy;
    memOp_e op;
  } opInfo_t;

  localparam logic [7:0] OPC_MODE4_ON  = 8'hB7;
  localparam logic [7:0] OPC_MODE4_OFF = 8'hE9;
  localparam logic [7:0] OPC_WE_SET    = 8'h06;
  localparam logic [7:0] OPC_WE_CLR    = 8'h04;
  localparam logic [7:0] OPC_FLAGS     = 8'h70;
  localparam logic [7:0] OPC_EXT_RD    = 8'hC8;
  localparam logic [7:0] OPC_EXT_WR    = 8'hC5;
  localparam logic [7:0] OPC_NV_RD     = 8'hB5;
  localparam logic [7:0] OPC_NV_WR     = 8'hB1;
  localparam logic [7:0] OPC_VC_RD     = 8'h85;
  localparam logic [7:0] OPC_VC_WR     = 8'h81;
  localparam logic [7:0] OPC_EVC_RD    = 8'h65;
  localparam logic [7:0] OPC_EVC_WR    = 8'h61;
  localparam logic [7:0] OPC_RST_ARM   = 8'h66;
  localparam logic [7:0] OPC_RST_GO    = 8'h99;

  function automatic logic isArrayOp(logic [7:0] o);
    case (o)
      8'h03, 8'h13, 8'h0B, 8'h0C, 8'h3B, 8'h3C, 8'h6B, 8'h6C,
      8'hBB, 8'hBC, 8'hEB, 8'hEC, 8'h02, 8'h12, 8'hA2, 8'h32,
      8'h20, 8'h21, 8'hD8, 8'hDC: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic opInfo_t arrayInfo(logic [7:0] o);
    opInfo_t r;
    r = '{force4: 1'b0, hasDummy: 1'b0, op: MEM_READ};
    case (o)
      8'h13: r.force4 = 1'b1;
      8'h0B, 8'h3B, 8'h6B, 8'hBB, 8'hEB: r.hasDummy = 1'b1;
      8'h0C, 8'h3C, 8'h6C, 8'hBC, 8'hEC: begin r.hasDummy = 1'b1; r.force4 = 1'b1; end
      8'h02, 8'hA2, 8'h32: r.op = MEM_PROG;
      8'h12: begin r.op = MEM_PROG; r.force4 = 1'b1; end
      8'h20: r.op = MEM_ERASE_4K;
      8'h21: begin r.op = MEM_ERASE_4K; r.force4 = 1'b1; end
      8'hD8: r.op = MEM_ERASE_SECT;
      8'hDC: begin r.op = MEM_ERASE_SECT; r.force4 = 1'b1; end
      default: ;
    endcase
    return r;
  endfunction

  function automatic logic isRegRead(logic [7:0] o);
    return (o == OPC_FLAGS) || (o == OPC_EXT_RD) || (o == OPC_NV_RD) ||
           (o == OPC_VC_RD) || (o == OPC_EVC_RD);
  endfunction

  function automatic logic isRegWrite(logic [7:0] o);
    return (o == OPC_EXT_WR) || (o == OPC_NV_WR) || (o == OPC_VC_WR) || (o == OPC_EVC_WR);
  endfunction

  function automatic logic [7:0] bootVcfg(logic [15:0] nv);
    return {nv[15:12], (nv[11:9] != 3'b111), 1'b0, 2'b11};
  endfunction

  function automatic logic [7:0] bootEvcfg(logic [15:0] nv);
    return {nv[3], nv[2], 1'b0, 5'h1F};
  endfunction

  function automatic logic [7:0] bootEar(logic [15:0] nv);
    return nv[1] ? 8'h00 : 8'h03;
  endfunction

endpackage

// File: rtl/spiflash_ctrl.sv
module spiflash_ctrl
  import spiflash_pkg::*;
#(
  parameter int DUMMY_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               csN,
  input  logic               rxValid,
  input  logic [7:0]         rxData,
  input  logic               txReq,
  input  logic               fourByte,
  input  logic               wren,
  input  logic [DUMMY_W-1:0] dummyCnt,
  output dpCtl_t             ctl,
  output logic               memReq,
  output memOp_e             memOp
);
  localparam int CNT_W = DUMMY_W + 1;

  st_e              state;
  logic [7:0]       opc;
  opInfo_t          cur;
  logic [CNT_W-1:0] cnt;
  logic             armed;
  logic             hiByte;
  logic             addr4;
  logic [CNT_W-1:0] addrLast;
  logic [CNT_W-1:0] dummyLast;

  assign addr4     = cur.force4 | fourByte;
  assign addrLast  = addr4 ? CNT_W'(3) : CNT_W'(2);
  assign dummyLast = {1'b0, dummyCnt} - 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_OPC;
      opc    <= '0;
      cur    <= '0;
      cnt    <= '0;
      armed  <= 1'b0;
      hiByte <= 1'b0;
    end else if (csN) begin
      state  <= ST_OPC;
      cnt    <= '0;
      hiByte <= 1'b0;
    end else begin
      case (state)
        ST_OPC: if (rxValid) begin
          opc    <= rxData;
          cur    <= arrayInfo(rxData);
          armed  <= (rxData == OPC_RST_ARM);
          cnt    <= '0;
          hiByte <= 1'b0;
          if (isArrayOp(rxData))                  state <= ST_ADDR;
          else if (isRegRead(rxData))             state <= ST_REGRD;
          else if (isRegWrite(rxData) && wren)    state <= ST_REGWR;
          else                                    state <= ST_SKIP;
        end
        ST_ADDR: if (rxValid) begin
          if (cnt == addrLast) begin
            cnt <= '0;
            case (cur.op)
              MEM_READ: state <= (cur.hasDummy && dummyCnt != '0) ? ST_DUMMY : ST_ARRRD;
              MEM_PROG: state <= ST_PROG;
              default:  state <= ST_ERASE;
            endcase
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DUMMY: if (rxValid) begin
          if (cnt == dummyLast) state <= ST_ARRRD;
          else                  cnt   <= cnt + 1'b1;
        end
        ST_ERASE: state <= ST_SKIP;
        ST_REGRD: if (txReq) hiByte <= 1'b1;
        ST_REGWR: if (rxValid) begin
          cnt <= cnt + 1'b1;
          if (opc != OPC_NV_WR || cnt != '0) state <= ST_SKIP;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    ctl       = '0;
    ctl.addr4 = addr4;
    memReq    = 1'b0;
    memOp     = MEM_READ;
    if (!csN) begin
      case (state)
        ST_OPC: if (rxValid) begin
          ctl.setFour = (rxData == OPC_MODE4_ON);
          ctl.clrFour = (rxData == OPC_MODE4_OFF);
          ctl.setWe   = (rxData == OPC_WE_SET);
          ctl.clrWe   = (rxData == OPC_WE_CLR);
          ctl.doReset = (rxData == OPC_RST_GO) && armed;
        end
        ST_ADDR: ctl.shiftAddr = rxValid;
        ST_ARRRD: begin
          ctl.rdSel = RS_ARRAY;
          if (txReq) begin
            memReq      = 1'b1;
            memOp       = MEM_READ;
            ctl.incAddr = 1'b1;
          end
        end
        ST_PROG: if (rxValid) begin
          memReq      = 1'b1;
          memOp       = MEM_PROG;
          ctl.incAddr = 1'b1;
        end
        ST_ERASE: begin
          memReq = 1'b1;
          memOp  = cur.op;
        end
        ST_REGRD: begin
          ctl.hiByte = hiByte;
          case (opc)
            OPC_FLAGS:  ctl.rdSel = RS_FLAG;
            OPC_EXT_RD: ctl.rdSel = RS_EAR;
            OPC_NV_RD:  ctl.rdSel = RS_NVCFG;
            OPC_VC_RD:  ctl.rdSel = RS_VCFG;
            default:    ctl.rdSel = RS_EVCFG;
          endcase
        end
        ST_REGWR: if (rxValid) begin
          ctl.loadEar   = (opc == OPC_EXT_WR);
          ctl.loadVcfg  = (opc == OPC_VC_WR);
          ctl.loadEvcfg = (opc == OPC_EVC_WR);
          ctl.nvLow     = (opc == OPC_NV_WR) && (cnt == '0);
          ctl.nvHigh    = (opc == OPC_NV_WR) && (cnt != '0);
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/spiflash_dp.sv
module spiflash_dp
  import spiflash_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          DUMMY_W  = 4,
  parameter logic [15:0] NV_RESET = 16'h8FFF
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtl_t             ctl,
  input  logic [7:0]         rxData,
  input  logic [7:0]         memRdata,
  output logic [7:0]         txData,
  output logic [ADDR_W-1:0]  memAddr,
  output logic               fourByte,
  output logic               wren,
  output logic [DUMMY_W-1:0] dummyCnt
);
  logic [15:0]       nvCfg;
  logic [7:0]        nvTmp;
  logic [7:0]        vCfg;
  logic [7:0]        evCfg;
  logic [7:0]        extAddr;
  logic [ADDR_W-1:0] addrReg;
  logic [ADDR_W-1:0] addrShifted;

  assign addrShifted = ctl.addr4 ? {addrReg[ADDR_W-9:0], rxData}
                                 : ADDR_W'({extAddr[1:0], addrReg[15:0], rxData});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nvCfg    <= NV_RESET;
      nvTmp    <= '0;
      vCfg     <= bootVcfg(NV_RESET);
      evCfg    <= bootEvcfg(NV_RESET);
      extAddr  <= bootEar(NV_RESET);
      fourByte <= ~NV_RESET[0];
      wren     <= 1'b0;
      addrReg  <= '0;
    end else begin
      if (ctl.doReset) begin
        vCfg     <= bootVcfg(nvCfg);
        evCfg    <= bootEvcfg(nvCfg);
        extAddr  <= bootEar(nvCfg);
        fourByte <= ~nvCfg[0];
        wren     <= 1'b0;
      end else begin
        if (ctl.setFour)   fourByte <= 1'b1;
        if (ctl.clrFour)   fourByte <= 1'b0;
        if (ctl.setWe)     wren     <= 1'b1;
        if (ctl.clrWe)     wren     <= 1'b0;
        if (ctl.loadEar)   extAddr  <= rxData;
        if (ctl.loadVcfg)  vCfg     <= rxData;
        if (ctl.loadEvcfg) evCfg    <= rxData;
        if (ctl.nvLow)     nvTmp    <= rxData;
        if (ctl.nvHigh)    nvCfg    <= {rxData, nvTmp};
      end
      if (ctl.shiftAddr)    addrReg <= addrShifted;
      else if (ctl.incAddr) addrReg <= addrReg + 1'b1;
    end
  end

  always_comb begin
    case (ctl.rdSel)
      RS_ARRAY: txData = memRdata;
      RS_FLAG:  txData = {7'b1000000, fourByte};
      RS_EAR:   txData = extAddr;
      RS_NVCFG: txData = ctl.hiByte ? nvCfg[15:8] : nvCfg[7:0];
      RS_VCFG:  txData = vCfg;
      RS_EVCFG: txData = evCfg;
      default:  txData = 8'hFF;
    endcase
  end

  assign memAddr  = addrReg;
  assign dummyCnt = vCfg[7:8-DUMMY_W];

endmodule

// File: rtl/spiflash_cmd_front.sv
module spiflash_cmd_front
  import spiflash_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter logic [15:0] NV_RESET = 16'h8FFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  input  logic              txReq,
  output logic [7:0]        txData,
  output logic              memReq,
  output logic [1:0]        memOp,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  input  logic [7:0]        memRdata
);
  localparam int DUMMY_W = 4;

  dpCtl_t             ctl;
  memOp_e             opEnum;
  logic               fourByte;
  logic               wren;
  logic [DUMMY_W-1:0] dummyCnt;

  spiflash_ctrl #(.DUMMY_W(DUMMY_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .csN(csN), .rxValid(rxValid), .rxData(rxData),
    .txReq(txReq), .fourByte(fourByte), .wren(wren), .dummyCnt(dummyCnt),
    .ctl(ctl), .memReq(memReq), .memOp(opEnum)
  );

  spiflash_dp #(.ADDR_W(ADDR_W), .DUMMY_W(DUMMY_W), .NV_RESET(NV_RESET)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rxData(rxData), .memRdata(memRdata),
    .txData(txData), .memAddr(memAddr), .fourByte(fourByte), .wren(wren),
    .dummyCnt(dummyCnt)
  );

  assign memOp    = opEnum;
  assign memWdata = rxData;

endmodule

// File: rtl/spiflash_cmd_front_chk.sv
module spiflash_cmd_front_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              rxValid,
  input logic              memReq,
  input logic [1:0]        memOp,
  input logic [ADDR_W-1:0] memAddr,
  input logic              fourByte,
  input logic              wren,
  input logic              doReset
);

  p_no_req_cs_high_r12: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !memReq);

  p_read_addr_inc_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memOp == 2'd0) |=> memAddr == $past(memAddr) + 1'b1);

  p_prog_addr_inc_r7: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memOp == 2'd1) |=> memAddr == $past(memAddr) + 1'b1);

  p_erase_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memOp[1]) |=> !memReq);

  p_mode_needs_byte_r2: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |=> $stable(fourByte));

  p_reset_clears_we_r11: assert property (@(posedge clk) disable iff (!rstN)
    doReset |=> !wren);

endmodule

bind spiflash_cmd_front spiflash_cmd_front_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .csN(csN), .rxValid(rxValid), .memReq(memReq),
  .memOp(memOp), .memAddr(memAddr), .fourByte(fourByte), .wren(wren),
  .doReset(ctl.doReset)
);

// File: tb/spiflash_cmd_front_tb_top.sv
module spiflash_cmd_front_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = 8'h00;
  logic        txReq = 1'b0;
  logic [7:0]  txData;
  logic        memReq;
  logic [1:0]  memOp;
  logic [31:0] memAddr;
  logic [7:0]  memWdata;
  logic [7:0]  memRdata;

  always #4 clk = ~clk;

  spiflash_cmd_front dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .rxValid(rxValid), .rxData(rxData),
    .txReq(txReq), .txData(txData), .memReq(memReq), .memOp(memOp),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata)
  );

  logic [7:0] mem [256];
  initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
  assign memRdata = mem[memAddr[7:0]];

  typedef struct {
    logic [1:0]  op;
    logic [31:0] addr;
    logic [7:0]  data;
    string       tag;
  } req_t;
  req_t expQ[$];

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    req_t e;
    if (rstN && memReq) begin
      if (expQ.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R12 unexpected request actual=op%0d/%h expected=none", memOp, memAddr);
      end else begin
        e = expQ.pop_front();
        chk({e.tag, " op"}, {30'd0, memOp}, {30'd0, e.op});
        chk({e.tag, " addr"}, memAddr, e.addr);
        if (e.op == 2'd1) chk({e.tag, " data"}, {24'd0, memWdata}, {24'd0, e.data});
      end
      if (memOp == 2'd1) mem[memAddr[7:0]] = mem[memAddr[7:0]] & memWdata;
    end
  end

  task automatic expectReq(input logic [1:0] op, input logic [31:0] a, input logic [7:0] d,
                           input string tag);
    req_t e;
    e.op = op; e.addr = a; e.data = d; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic sendB(input logic [7:0] b);
    rxValid = 1'b1; rxData = b;
    @(posedge clk); #1;
    rxValid = 1'b0;
  endtask

  task automatic getB(input logic [7:0] exp, input string tag);
    txReq = 1'b1;
    @(negedge clk);
    chk(tag, {24'd0, txData}, {24'd0, exp});
    @(posedge clk); #1;
    txReq = 1'b0;
  endtask

  task automatic openF;
    csN = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic closeF;
    csN = 1'b1;
    repeat (2) begin @(posedge clk); #1; end
  endtask

  task automatic cmd1(input logic [7:0] b);
    openF(); sendB(b); closeF();
  endtask

  task automatic cmd2(input logic [7:0] b, input logic [7:0] d);
    openF(); sendB(b); sendB(d); closeF();
  endtask

  task automatic rdReg(input logic [7:0] o, input logic [7:0] exp, input string tag);
    openF(); sendB(o); getB(exp, tag); closeF();
  endtask

  task automatic dummies(input int n);
    for (int i = 0; i < n; i++) sendB(8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;

    // R1 power-on register values
    rdReg(8'h85, 8'h83, "R1 vcfg");
    rdReg(8'h65, 8'hDF, "R1 evcfg");
    openF(); sendB(8'hB5); getB(8'hFF, "R1 nv low"); getB(8'h8F, "R1 nv high"); closeF();
    rdReg(8'h70, 8'h80, "R1 flags");
    rdReg(8'hC8, 8'h00, "R1 ear");

    // R3 / R6 legacy read, 3-byte address
    expectReq(2'd0, 32'h10, 8'h00, "R3 read");
    expectReq(2'd0, 32'h11, 8'h00, "R6 read inc");
    openF(); sendB(8'h03); sendB(8'h00); sendB(8'h00); sendB(8'h10);
    getB(8'h10 ^ 8'h5A, "R6 data0"); getB(8'h11 ^ 8'h5A, "R6 data1"); closeF();

    // R7 program then read back AND-merged data
    expectReq(2'd1, 32'h20, 8'h0F, "R7 prog0");
    expectReq(2'd1, 32'h21, 8'hF0, "R7 prog1");
    openF(); sendB(8'h02); sendB(8'h00); sendB(8'h00); sendB(8'h20);
    sendB(8'h0F); sendB(8'hF0); closeF();
    expectReq(2'd0, 32'h20, 8'h00, "R7 readback");
    expectReq(2'd0, 32'h21, 8'h00, "R7 readback");
    openF(); sendB(8'h03); sendB(8'h00); sendB(8'h00); sendB(8'h20);
    getB(8'h0A, "R7 and0"); getB(8'h70, "R7 and1"); closeF();

    // R2 4-byte mode with legacy read
    cmd1(8'hB7);
    rdReg(8'h70, 8'h81, "R2 flags mode on");
    expectReq(2'd0, 32'h01000030, 8'h00, "R2 legacy read 4-byte");
    openF(); sendB(8'h03); sendB(8'h01); sendB(8'h00); sendB(8'h00); sendB(8'h30);
    getB(8'h30 ^ 8'h5A, "R2 data"); closeF();
    cmd1(8'hE9);
    rdReg(8'h70, 8'h80, "R2 flags mode off");

    // R4 dedicated 4-byte read in 3-byte mode
    expectReq(2'd0, 32'h02000040, 8'h00, "R4 read4");
    openF(); sendB(8'h13); sendB(8'h02); sendB(8'h00); sendB(8'h00); sendB(8'h40);
    getB(8'h40 ^ 8'h5A, "R4 data"); closeF();

    // R9 extended address register and write-enable
    cmd2(8'hC5, 8'h02);
    rdReg(8'hC8, 8'h00, "R9 ear write ignored");
    cmd1(8'h06);
    cmd2(8'hC5, 8'h02);
    rdReg(8'hC8, 8'h02, "R9 ear written");
    expectReq(2'd0, 32'h02000050, 8'h00, "R3 ext offset");
    openF(); sendB(8'h03); sendB(8'h00); sendB(8'h00); sendB(8'h50);
    getB(8'h50 ^ 8'h5A, "R3 data"); closeF();
    cmd1(8'h04);
    cmd2(8'hC5, 8'h01);
    rdReg(8'hC8, 8'h02, "R9 ignored after clear");

    // R5 dummy bytes
    expectReq(2'd0, 32'h02000060, 8'h00, "R5 fast read 8 dummies");
    openF(); sendB(8'h0B); sendB(8'h00); sendB(8'h00); sendB(8'h60); dummies(8);
    getB(8'h60 ^ 8'h5A, "R5 data8"); closeF();
    cmd1(8'h06);
    cmd2(8'h81, 8'h23);
    rdReg(8'h85, 8'h23, "R10 vcfg written");
    expectReq(2'd0, 32'h02000070, 8'h00, "R5 fast read 2 dummies");
    openF(); sendB(8'h0B); sendB(8'h00); sendB(8'h00); sendB(8'h70); dummies(2);
    getB(8'h70 ^ 8'h5A, "R5 data2"); closeF();
    expectReq(2'd0, 32'h00000080, 8'h00, "R4 quad io read4");
    openF(); sendB(8'hEC); sendB(8'h00); sendB(8'h00); sendB(8'h00); sendB(8'h80); dummies(2);
    getB(8'h80 ^ 8'h5A, "R5 data quad"); closeF();

    // R8 erase
    expectReq(2'd2, 32'h02001000, 8'h00, "R8 erase 4K");
    openF(); sendB(8'h20); sendB(8'h00); sendB(8'h10); sendB(8'h00);
    @(posedge clk); #1; closeF();
    expectReq(2'd3, 32'h00002000, 8'h00, "R8 erase sector4");
    openF(); sendB(8'hDC); sendB(8'h00); sendB(8'h00); sendB(8'h20); sendB(8'h00);
    @(posedge clk); #1; closeF();

    // R12 abort partial frame
    openF(); sendB(8'h03); sendB(8'h00); sendB(8'h00); closeF();
    rdReg(8'h70, 8'h80, "R12 opcode after abort");

    // R10 configuration writes
    cmd1(8'h04);
    openF(); sendB(8'hB1); sendB(8'h34); sendB(8'h12); closeF();
    openF(); sendB(8'hB5); getB(8'hFF, "R10 nv ignored low"); getB(8'h8F, "R10 nv ignored high"); closeF();
    cmd1(8'h06);
    openF(); sendB(8'hB1); sendB(8'h04); sendB(8'h50); closeF();
    openF(); sendB(8'hB5); getB(8'h04, "R10 nv low"); getB(8'h50, "R10 nv high"); closeF();
    cmd2(8'h61, 8'h11);
    rdReg(8'h65, 8'h11, "R10 evcfg written");

    // R11 reset sequence
    cmd1(8'h99);
    rdReg(8'h85, 8'h23, "R11 bare reset ignored");
    cmd1(8'h66);
    cmd1(8'h70);
    cmd1(8'h99);
    rdReg(8'h85, 8'h23, "R11 disarmed reset ignored");
    cmd1(8'h66);
    cmd1(8'h99);
    rdReg(8'h85, 8'h5B, "R11 vcfg derived");
    rdReg(8'h65, 8'h5F, "R11 evcfg derived");
    rdReg(8'h70, 8'h81, "R11 4-byte derived");
    rdReg(8'hC8, 8'h03, "R11 ear derived");
    cmd2(8'hC5, 8'h05);
    rdReg(8'hC8, 8'h03, "R11 write-enable cleared");
    expectReq(2'd0, 32'h00000090, 8'h00, "R11 4-byte legacy read");
    openF(); sendB(8'h03); sendB(8'h00); sendB(8'h00); sendB(8'h00); sendB(8'h90);
    getB(8'h90 ^ 8'h5A, "R11 data"); closeF();

    repeat (4) @(posedge clk);
    chk("R12 leftover expected requests", expQ.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule